// File: doc/BRIEF.md
# Double-Buffered Bulk OUT Endpoint Controller

This block manages a pair of packet buffers behind one bulk OUT endpoint. The host can deliver a fresh packet into one buffer while software, or a DMA engine, is still draining the packet held in the other. The block does not hold the packet bytes. It produces the write address and buffer select for the host side, and it produces the read address for the software side. For each buffer it keeps a full flag and the received byte count.

At any moment one buffer is the active buffer, the one software reads. The active buffer changes only when software issues a clear command while that buffer holds a packet. An incoming packet goes into the active buffer when it is empty. Otherwise it goes into the other buffer. When both buffers hold packets, the packet is refused with NAK and its bytes are dropped. Every stored packet raises a sticky endpoint interrupt flag, which software clears with a one-cycle pulse.

The host side is a receive state machine with three states. RX_IDLE waits for a packet start. RX_FILL writes the bytes into the chosen buffer. RX_DROP swallows the bytes of a refused packet. The transitions are START_ACCEPT (RX_IDLE to RX_FILL), START_NAK (RX_IDLE to RX_DROP), FILL_END (RX_FILL to RX_IDLE, which stores the packet) and DROP_END (RX_DROP to RX_IDLE).

Top module: `dbuf_out_ep`

## Requirements
- R1: After reset both buffers are empty (`buf_full` = 0), the active buffer is buffer 0 (`act_sel` = 0), `act_full` is 0 and `irq` is 0.
- R2: A packet that starts while the active buffer is empty is written into the active buffer. `wr_addr` holds the buffer index in its top bit and the byte offset in its lower ADDR_W bits. The offset starts at 0 and rises by one for each byte, and `wr_data` carries `pkt_data`.
- R3: A packet that starts while the active buffer is full and the other buffer is empty is written into the other buffer, and the active buffer stays unchanged.
- R4: A packet that starts while both buffers are full is answered with `pkt_nak` high in the cycle of `pkt_start`. None of its bytes raises `wr_en`, and neither the full flags nor the interrupt flag change.
- R5: The `pkt_end` of an accepted packet marks its buffer full, stores its byte count and sets `irq`. All three are visible from the next cycle.
- R6: `irq` stays high until a cycle with `irq_clr` high. A packet stored in the same cycle as `irq_clr` leaves `irq` high.
- R7: A `clr_buf` pulse while the active buffer is full marks that buffer empty and makes the other buffer active from the next cycle.
- R8: A `clr_buf` pulse while the active buffer is empty is ignored. `act_sel` and `buf_full` keep their values.
- R9: `act_len` shows the stored byte count of the active buffer. `rd_addr` is `{act_sel, rd_offset}`.
- R10: Bytes after the first MAX_PKT bytes of a packet are not written, and the stored count saturates at MAX_PKT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pkt_start | input | 1 | Host packet begins (one-cycle pulse) |
| pkt_byte | input | 1 | One packet byte is present on pkt_data |
| pkt_data | input | DATA_W | Packet byte |
| pkt_end | input | 1 | Host packet complete (one-cycle pulse, carries no byte) |
| pkt_nak | output | 1 | Packet refused because both buffers are full |
| wr_en | output | 1 | Write strobe toward the buffer RAM |
| wr_addr | output | ADDR_W+1 | Write address: buffer index in the top bit, then the byte offset |
| wr_data | output | DATA_W | Byte to write |
| clr_buf | input | 1 | Software command that frees the active buffer |
| rd_offset | input | ADDR_W | Software read offset in the active buffer |
| rd_addr | output | ADDR_W+1 | Read address in the active buffer |
| act_sel | output | 1 | Index of the active buffer |
| act_full | output | 1 | Active buffer holds a packet |
| act_len | output | LEN_W | Byte count of the active buffer's packet |
| buf_full | output | 2 | Full flag of each buffer |
| irq | output | 1 | Sticky endpoint interrupt |
| irq_clr | input | 1 | Clears irq (one-cycle pulse) |

## Verification
The bench builds the block with MAX_PKT = 8, so ADDR_W is 3 and LEN_W is 4. With this size, a ten-byte packet overruns a buffer quickly, which exercises write suppression and count saturation at the MAX_PKT limit. The small address field also keeps every expected write address easy to compute. The sequence fills both buffers, forces a NAK, and then walks the active buffer back and forth with clear commands, including a clear while the active buffer is empty. It also clears the interrupt in the same cycle that a packet is stored.

// File: rtl/dbuf_pkg.sv
package dbuf_pkg;

    typedef enum logic [1:0] {
        RX_IDLE = 2'd0,
        RX_FILL = 2'd1,
        RX_DROP = 2'd2
    } rx_state_e;

endpackage

// File: rtl/dbuf_rx_fsm.sv
module dbuf_rx_fsm
    import dbuf_pkg::*;
#(
    parameter int MAX_PKT = 64,
    localparam int ADDR_W = $clog2(MAX_PKT),
    localparam int LEN_W  = $clog2(MAX_PKT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pkt_start,
    input  logic              pkt_byte,
    input  logic              pkt_end,
    input  logic              tgt_ok,
    input  logic              tgt_sel,
    output logic              nak,
    output logic              wr_en,
    output logic              wr_sel,
    output logic [ADDR_W-1:0] wr_off,
    output logic              commit,
    output logic              commit_sel,
    output logic [LEN_W-1:0]  commit_len
);

    rx_state_e        state_q, state_d;
    logic [LEN_W-1:0] cnt_q;
    logic             sel_q;
    logic             room;

    assign room = (cnt_q < LEN_W'(MAX_PKT));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE: begin
                if (pkt_start) begin
                    state_d = tgt_ok ? RX_FILL : RX_DROP; // START_ACCEPT / START_NAK
                end
            end
            RX_FILL: begin
                if (pkt_end) state_d = RX_IDLE;           // FILL_END
            end
            RX_DROP: begin
                if (pkt_end) state_d = RX_IDLE;           // DROP_END
            end
            default: state_d = RX_IDLE;
        endcase
    end

    // byte counter and target latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            sel_q <= 1'b0;
        end else if (state_q == RX_IDLE && pkt_start && tgt_ok) begin
            cnt_q <= '0;
            sel_q <= tgt_sel;
        end else if (state_q == RX_FILL && pkt_byte && room) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        nak        = 1'b0;
        wr_en      = 1'b0;
        commit     = 1'b0;
        wr_sel     = sel_q;
        wr_off     = cnt_q[ADDR_W-1:0];
        commit_sel = sel_q;
        commit_len = cnt_q;
        unique case (state_q)
            RX_IDLE: nak    = pkt_start && !tgt_ok;
            RX_FILL: begin
                wr_en  = pkt_byte && room;
                commit = pkt_end;
            end
            RX_DROP: ;
            default: ;
        endcase
    end

endmodule

// File: rtl/dbuf_bank.sv
module dbuf_bank #(
    parameter int MAX_PKT = 64,
    localparam int LEN_W = $clog2(MAX_PKT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             commit,
    input  logic             commit_sel,
    input  logic [LEN_W-1:0] commit_len,
    input  logic             clr,
    output logic             tgt_ok,
    output logic             tgt_sel,
    output logic             act_sel,
    output logic             act_full,
    output logic [LEN_W-1:0] act_len,
    output logic [1:0]       full
);

    localparam int NBUF = 2;

    logic             act_q;
    logic             clr_take;
    logic [LEN_W-1:0] len_v [NBUF];

    assign clr_take = clr && full[act_q];

    for (genvar b = 0; b < NBUF; b++) begin : g_buf
        logic             full_q;
        logic [LEN_W-1:0] len_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                full_q <= 1'b0;
                len_q  <= '0;
            end else if (commit && commit_sel == 1'(b)) begin
                full_q <= 1'b1;
                len_q  <= commit_len;
            end else if (clr_take && act_q == 1'(b)) begin
                full_q <= 1'b0;
            end
        end
        assign full[b]  = full_q;
        assign len_v[b] = len_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q <= 1'b0;
        end else if (clr_take) begin
            act_q <= ~act_q;
        end
    end

    assign tgt_ok   = !(full[0] && full[1]);
    assign tgt_sel  = full[act_q] ? ~act_q : act_q;
    assign act_sel  = act_q;
    assign act_full = full[act_q];
    assign act_len  = len_v[act_q];

endmodule

// File: rtl/dbuf_irq.sv
module dbuf_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (set) begin
            flag <= 1'b1;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end

endmodule

// File: rtl/dbuf_out_ep.sv
module dbuf_out_ep #(
    parameter int MAX_PKT = 64,
    parameter int DATA_W  = 8,
    localparam int ADDR_W = $clog2(MAX_PKT),
    localparam int LEN_W  = $clog2(MAX_PKT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pkt_start,
    input  logic              pkt_byte,
    input  logic [DATA_W-1:0] pkt_data,
    input  logic              pkt_end,
    output logic              pkt_nak,
    output logic              wr_en,
    output logic [ADDR_W:0]   wr_addr,
    output logic [DATA_W-1:0] wr_data,
    input  logic              clr_buf,
    input  logic [ADDR_W-1:0] rd_offset,
    output logic [ADDR_W:0]   rd_addr,
    output logic              act_sel,
    output logic              act_full,
    output logic [LEN_W-1:0]  act_len,
    output logic [1:0]        buf_full,
    output logic              irq,
    input  logic              irq_clr
);

    logic              tgt_ok, tgt_sel;
    logic              wr_sel;
    logic [ADDR_W-1:0] wr_off;
    logic              commit, commit_sel;
    logic [LEN_W-1:0]  commit_len;

    dbuf_rx_fsm #(.MAX_PKT(MAX_PKT)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .pkt_start  (pkt_start),
        .pkt_byte   (pkt_byte),
        .pkt_end    (pkt_end),
        .tgt_ok     (tgt_ok),
        .tgt_sel    (tgt_sel),
        .nak        (pkt_nak),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_off     (wr_off),
        .commit     (commit),
        .commit_sel (commit_sel),
        .commit_len (commit_len)
    );

    dbuf_bank #(.MAX_PKT(MAX_PKT)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit     (commit),
        .commit_sel (commit_sel),
        .commit_len (commit_len),
        .clr        (clr_buf),
        .tgt_ok     (tgt_ok),
        .tgt_sel    (tgt_sel),
        .act_sel    (act_sel),
        .act_full   (act_full),
        .act_len    (act_len),
        .full       (buf_full)
    );

    dbuf_irq u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (commit),
        .clr   (irq_clr),
        .flag  (irq)
    );

    assign wr_addr = {wr_sel, wr_off};
    assign wr_data = pkt_data;
    assign rd_addr = {act_sel, rd_offset};

endmodule

// File: rtl/dbuf_out_ep_chk.sv
module dbuf_out_ep_chk #(
    parameter int MAX_PKT = 64,
    localparam int ADDR_W = $clog2(MAX_PKT),
    localparam int LEN_W  = $clog2(MAX_PKT + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pkt_start,
    input logic             pkt_nak,
    input logic             wr_en,
    input logic [ADDR_W:0]  wr_addr,
    input logic             clr_buf,
    input logic             act_sel,
    input logic             act_full,
    input logic [LEN_W-1:0] act_len,
    input logic [1:0]       buf_full,
    input logic             irq,
    input logic             irq_clr
);

    AST_NAK_BOTH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_nak |-> (buf_full == 2'b11 && pkt_start)); // R4

    AST_WR_FREE_BUF: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !buf_full[wr_addr[ADDR_W]]); // R2

    AST_FILL_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(buf_full[0]) || $rose(buf_full[1])) |-> irq); // R5

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr) |=> irq); // R6

    AST_CLR_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_buf && act_full) |=> (act_sel != $past(act_sel))); // R7

    AST_CLR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_buf && !act_full) |=> $stable(act_sel)); // R8

    AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        act_len <= LEN_W'(MAX_PKT)); // R10

endmodule

bind dbuf_out_ep dbuf_out_ep_chk #(.MAX_PKT(MAX_PKT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pkt_start (pkt_start),
    .pkt_nak   (pkt_nak),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .clr_buf   (clr_buf),
    .act_sel   (act_sel),
    .act_full  (act_full),
    .act_len   (act_len),
    .buf_full  (buf_full),
    .irq       (irq),
    .irq_clr   (irq_clr)
);

// File: tb/dbuf_out_ep_bench.sv
module dbuf_out_ep_bench;

    localparam int MAX_PKT = 8;
    localparam int DATA_W  = 8;
    localparam int ADDR_W  = $clog2(MAX_PKT);
    localparam int LEN_W   = $clog2(MAX_PKT + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              pkt_start = 1'b0;
    logic              pkt_byte = 1'b0;
    logic [DATA_W-1:0] pkt_data = '0;
    logic              pkt_end = 1'b0;
    logic              pkt_nak;
    logic              wr_en;
    logic [ADDR_W:0]   wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic              clr_buf = 1'b0;
    logic [ADDR_W-1:0] rd_offset = '0;
    logic [ADDR_W:0]   rd_addr;
    logic              act_sel;
    logic              act_full;
    logic [LEN_W-1:0]  act_len;
    logic [1:0]        buf_full;
    logic              irq;
    logic              irq_clr = 1'b0;

    int checks = 0;
    int errors = 0;
    int exp_q[$];

    always #5 clk = ~clk;

    dbuf_out_ep #(.MAX_PKT(MAX_PKT), .DATA_W(DATA_W)) u_dbuf_out_ep (
        .clk(clk), .rst_n(rst_n), .pkt_start(pkt_start), .pkt_byte(pkt_byte),
        .pkt_data(pkt_data), .pkt_end(pkt_end), .pkt_nak(pkt_nak), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .clr_buf(clr_buf), .rd_offset(rd_offset),
        .rd_addr(rd_addr), .act_sel(act_sel), .act_full(act_full), .act_len(act_len),
        .buf_full(buf_full), .irq(irq), .irq_clr(irq_clr)
    );

    task automatic chk(string req, string what, int actual, int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, actual, expected);
        end
    endtask

    // monitor: pop expected writes as the design produces them
    always @(negedge clk) begin
        if (rst_n && wr_en) begin
            if (exp_q.size() == 0) begin
                chk("R4", "unexpected write addr", int'(wr_addr), -1);
            end else begin
                int e;
                e = exp_q.pop_front();
                chk("R2", "write addr", int'(wr_addr), e >> 8);
                chk("R2", "write data", int'(wr_data), e & 255);
            end
        end
    end

    // driver: one host packet of n bytes
    task automatic send_pkt(int n, int sel, bit nak_exp, bit clr_irq_at_end, string req);
        @(posedge clk); #1;
        pkt_start = 1'b1;
        @(negedge clk);
        chk(req, "pkt_nak", int'(pkt_nak), int'(nak_exp));
        @(posedge clk); #1;
        pkt_start = 1'b0;
        for (int i = 0; i < n; i++) begin
            pkt_byte = 1'b1;
            pkt_data = DATA_W'(i * 17 + n);
            if (!nak_exp && i < MAX_PKT)
                exp_q.push_back(((sel * MAX_PKT + i) << 8) | int'(pkt_data));
            @(posedge clk); #1;
        end
        pkt_byte = 1'b0;
        pkt_end  = 1'b1;
        irq_clr  = clr_irq_at_end;
        @(posedge clk); #1;
        pkt_end = 1'b0;
        irq_clr = 1'b0;
    endtask

    task automatic pulse_clr();
        @(posedge clk); #1;
        clr_buf = 1'b1;
        @(posedge clk); #1;
        clr_buf = 1'b0;
    endtask

    task automatic pulse_irq_clr();
        @(posedge clk); #1;
        irq_clr = 1'b1;
        @(posedge clk); #1;
        irq_clr = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        chk("R1", "buf_full", int'(buf_full), 0);
        chk("R1", "act_sel", int'(act_sel), 0);
        chk("R1", "act_full", int'(act_full), 0);
        chk("R1", "irq", int'(irq), 0);

        // R2/R5: first packet into active buffer 0
        send_pkt(5, 0, 1'b0, 1'b0, "R2");
        chk("R5", "buf_full", int'(buf_full), 1);
        chk("R5", "irq", int'(irq), 1);
        chk("R9", "act_len", int'(act_len), 5);
        chk("R9", "act_full", int'(act_full), 1);
        rd_offset = 3'd3;
        #1 chk("R9", "rd_addr", int'(rd_addr), 3);

        pulse_irq_clr();
        chk("R6", "irq after clear", int'(irq), 0);

        // R3: active full, packet goes to buffer 1
        send_pkt(3, 1, 1'b0, 1'b0, "R3");
        chk("R3", "buf_full", int'(buf_full), 3);
        chk("R3", "act_sel", int'(act_sel), 0);
        chk("R9", "act_len", int'(act_len), 5);
        pulse_irq_clr();

        // R4: both full -> NAK, nothing written
        send_pkt(4, 0, 1'b1, 1'b0, "R4");
        chk("R4", "buf_full", int'(buf_full), 3);
        chk("R4", "irq", int'(irq), 0);
        chk("R4", "act_len", int'(act_len), 5);

        // R7: clear frees buffer 0, buffer 1 becomes active
        pulse_clr();
        chk("R7", "act_sel", int'(act_sel), 1);
        chk("R7", "buf_full", int'(buf_full), 2);
        chk("R9", "act_len", int'(act_len), 3);
        #1 chk("R9", "rd_addr", int'(rd_addr), 11);

        // R10 + R6: overlong packet into buffer 0, irq clear coincides with store
        send_pkt(10, 0, 1'b0, 1'b1, "R10");
        chk("R6", "irq with coincident clear", int'(irq), 1);
        chk("R10", "buf_full", int'(buf_full), 3);
        chk("R3", "act_sel", int'(act_sel), 1);

        pulse_clr();
        chk("R7", "act_sel", int'(act_sel), 0);
        chk("R10", "act_len saturated", int'(act_len), 8);
        chk("R7", "buf_full", int'(buf_full), 1);

        pulse_clr();
        chk("R7", "act_sel", int'(act_sel), 1);
        chk("R7", "buf_full", int'(buf_full), 0);

        // R8: clear with empty active buffer is ignored
        pulse_clr();
        chk("R8", "act_sel", int'(act_sel), 1);
        chk("R8", "buf_full", int'(buf_full), 0);
        chk("R8", "act_full", int'(act_full), 0);

        // R2: both empty, active is buffer 1
        send_pkt(2, 1, 1'b0, 1'b0, "R2");
        chk("R2", "buf_full", int'(buf_full), 2);
        chk("R9", "act_len", int'(act_len), 2);
        chk("R5", "act_full", int'(act_full), 1);

        repeat (2) @(posedge clk);
        chk("R2", "pending expected writes", exp_q.size(), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule